// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the slave side of a three-wire serial port that gives a host access to a small register file, as found in clock and calendar devices. The host controls two chip-enable inputs, a shift clock and one data line that the block either samples or drives. All serial inputs are brought into a faster system clock through synchronizer flops, and every shift-clock edge is detected in that domain.

A transfer opens when both chip enables are high. The first byte shifted in, most significant bit first, is a command: its upper nibble is the start address and its lower nibble chooses the direction. Data bytes then follow. In a write, each completed byte lands in the register file. In a read, the block drives successive register contents onto the data line. After every byte the address steps by one and wraps around. When the main chip enable drops, three control bits in the last register are forced to zero. A separate frequency-output enable follows the auxiliary chip enable alone.

Top module: `ser3_regslave`

## Requirements
- R1: A transfer runs only while both `ce_main` and `ce_aux` are high after synchronization. A new transfer, with its bit count at zero, starts on each rising edge of that combined enable. Shift-clock activity while either enable is low changes no register.
- R2: While `ce_main` is low, `sdio_oe` is 0 in the same cycle, with no synchronizer delay.
- R3: The command byte carries the start address in bits [7:4] and a mode code in bits [3:0]. Code 4'b0011 selects write and code 4'b1100 selects read. All bytes are shifted most significant bit first.
- R4: In write mode, `sdio_in` is sampled on each `sclk` rising edge. Each complete 8-bit byte is stored at the current address.
- R5: A data byte with fewer than 8 bits received when the transfer ends is discarded, and its register keeps its previous value.
- R6: In read mode, the MSB of the register at the command address is presented on `sdio_out`, with `sdio_oe` at 1, directly after the command byte completes. Each `sclk` rising edge then moves the output to the next bit.
- R7: After each complete data byte, in either mode, the address increments, and it wraps from 15 to 0.
- R8: Any mode code other than the write and read codes makes the block ignore the rest of the transfer. Nothing is written and `sdio_oe` stays 0.
- R9: A falling edge of `ce_main` clears bits [2:0] of register 15 and leaves its other bits unchanged. A falling edge of `ce_aux` alone does not clear them.
- R10: `fout_en` equals `ce_aux` delayed by two system clocks, whatever the state of `ce_main`.
- R11: After reset, all 16 registers read 0, and `sdio_oe` and `fout_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than `sclk` |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_main | input | 1 | Main chip enable; gates access and the data driver |
| ce_aux | input | 1 | Auxiliary chip enable; gates access and the frequency output |
| sclk | input | 1 | Serial shift clock |
| sdio_in | input | 1 | Value received from the data line |
| sdio_out | output | 1 | Value to drive onto the data line |
| sdio_oe | output | 1 | Data-line drive enable; 0 means high impedance |
| fout_en | output | 1 | Frequency-output enable |

## Verification
Writes of several distinct byte patterns are read back. This separates bit order and field placement in the command from plain storage errors. Transfers that start at address 15 and run past it show the wrap to address 0. A transfer cut off in mid-byte, one with a reserved mode code, and one with only `ce_main` high each show that nothing is stored. Dropping `ce_aux` alone, and then `ce_main`, tells the control-bit clear apart from a plain end of transfer. A cycle-by-cycle model checks `fout_en` on every clock, and `sdio_oe` on every clock where `ce_main` is low.

// File: rtl/ser3_pkg.sv
package ser3_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_WRITE,
    PH_READ,
    PH_IGNORE
  } phase_t;

  localparam logic [3:0] MODE_WR = 4'b0011;
  localparam logic [3:0] MODE_RD = 4'b1100;

  // address step with wrap at the register count
  function automatic int unsigned wrap_inc(input int unsigned a, input int unsigned depth);
    return (a + 1 >= depth) ? 0 : a + 1;
  endfunction

  // phase entered once the command byte is complete
  function automatic phase_t decode_mode(input logic [3:0] m);
    if (m == MODE_WR) return PH_WRITE;
    if (m == MODE_RD) return PH_READ;
    return PH_IGNORE;
  endfunction

endpackage

// File: rtl/ser3_sync.sv
module ser3_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/ser3_regbank.sv
module ser3_regbank #(
  parameter int          DW       = 8,
  parameter int          AW       = 4,
  parameter int          CTRL_IDX = 15,
  parameter logic [7:0]  CLR_MASK = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          clr
);
  localparam int DEPTH = 1 << AW;
  localparam logic [DW-1:0] MASK = DW'(CLR_MASK);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (wr_en) mem[wr_addr] <= wr_data;
      if (clr) mem[CTRL_IDX] <= mem[CTRL_IDX] & ~MASK;
    end
  end

  assign rd_data = mem[rd_addr];

  // R9: a main-enable drop leaves the control bits at zero
  p_ctrl_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((mem[CTRL_IDX] & MASK) == '0));
endmodule

// File: rtl/ser3_engine.sv
module ser3_engine
  import ser3_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          access,
  input  logic          sclk_s,
  input  logic          sdio_s,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          drive,
  output logic          dout
);
  localparam int DEPTH = 1 << AW;
  localparam int BCW   = $clog2(DW);
  localparam int MW    = DW - AW;

  phase_t        phase;
  logic          sclk_d, access_d;
  logic [DW-1:0] sh, out_sr;
  logic [BCW-1:0] bcnt;
  logic [AW-1:0] addr;

  // named events for checking
  logic          sclk_rise, acc_rise, step, last_bit, byte_done;
  logic [DW-1:0] byte_in;
  logic [AW-1:0] addr_inc;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign acc_rise  = access & ~access_d;
  assign step      = access & ~acc_rise & sclk_rise & (phase != PH_IDLE);
  assign last_bit  = (bcnt == BCW'(DW - 1));
  assign byte_done = step & last_bit;
  assign byte_in   = {sh[DW-2:0], sdio_s};
  assign addr_inc  = AW'(wrap_inc(32'(addr), DEPTH));

  assign rd_addr = (phase == PH_CMD) ? byte_in[DW-1 -: AW] : addr_inc;
  assign wr_en   = byte_done & (phase == PH_WRITE);
  assign wr_addr = addr;
  assign wr_data = byte_in;
  assign drive   = (phase == PH_READ);
  assign dout    = out_sr[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      sclk_d   <= 1'b0;
      access_d <= 1'b0;
      sh       <= '0;
      out_sr   <= '0;
      bcnt     <= '0;
      addr     <= '0;
    end else begin
      sclk_d   <= sclk_s;
      access_d <= access;
      if (acc_rise) begin
        phase <= PH_CMD;
        bcnt  <= '0;
      end else if (!access) begin
        phase <= PH_IDLE;
        bcnt  <= '0;
      end else if (step) begin
        sh   <= byte_in;
        bcnt <= last_bit ? '0 : bcnt + 1'b1;
        case (phase)
          PH_CMD: if (last_bit) begin
            addr   <= byte_in[DW-1 -: AW];
            phase  <= decode_mode(4'(byte_in[MW-1:0]));
            out_sr <= rd_data;
          end
          PH_WRITE: if (last_bit) addr <= addr_inc;
          PH_READ: begin
            if (last_bit) begin
              addr   <= addr_inc;
              out_sr <= rd_data;
            end else begin
              out_sr <= {out_sr[DW-2:0], 1'b0};
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: every combined-enable rise restarts at the command byte
  p_restart_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rise |=> (phase == PH_CMD) && (bcnt == '0));
  // R5: a store happens only at the end of a full byte
  p_full_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (bcnt == '0));
  // R7: the address steps with wrap after each data byte
  p_addr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (phase == PH_WRITE || phase == PH_READ)) |=>
      (addr == AW'(wrap_inc(32'($past(addr)), DEPTH))));
  // R8: an ignored transfer neither stores nor drives
  p_ignore_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGNORE) |-> (!wr_en && !drive));
endmodule

// File: rtl/ser3_regslave.sv
module ser3_regslave #(
  parameter int         DW          = 8,
  parameter int         AW          = 4,
  parameter int         SYNC_STAGES = 2,
  parameter int         CTRL_IDX    = 15,
  parameter logic [7:0] CLR_MASK    = 8'h07
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_main,
  input  logic ce_aux,
  input  logic sclk,
  input  logic sdio_in,
  output logic sdio_out,
  output logic sdio_oe,
  output logic fout_en
);
  logic [3:0]    syn;
  logic          ce_main_s, ce_aux_s, sclk_s, sdio_s;
  logic          ce_main_d, access, clr, drive, dout, wr_en;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;

  ser3_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ce_main, ce_aux, sclk, sdio_in}), .q(syn)
  );
  assign {ce_main_s, ce_aux_s, sclk_s, sdio_s} = syn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_main_d <= 1'b0;
    else        ce_main_d <= ce_main_s;
  end

  assign access = ce_main_s & ce_aux_s;
  assign clr    = ce_main_d & ~ce_main_s;

  ser3_engine #(.DW(DW), .AW(AW)) u_eng (
    .clk(clk), .rst_n(rst_n), .access(access), .sclk_s(sclk_s), .sdio_s(sdio_s),
    .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .drive(drive), .dout(dout)
  );

  ser3_regbank #(.DW(DW), .AW(AW), .CTRL_IDX(CTRL_IDX), .CLR_MASK(CLR_MASK)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .clr(clr)
  );

  assign sdio_oe  = ce_main & drive;
  assign sdio_out = dout;
  assign fout_en  = ce_aux_s;

  // R1: the line is only driven inside an enabled transfer
  p_oe_in_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> $past(access));
  // R10: the frequency enable rises only after the aux enable was high
  p_fout_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fout_en) |-> $past(ce_aux));
endmodule

// File: tb/sim_ser3_regslave.sv
module sim_ser3_regslave;
  logic clk = 0, rst_n = 0;
  logic ce_main = 0, ce_aux = 0, sclk = 0, sdio_in = 0;
  logic sdio_out, sdio_oe, fout_en;
  int   checks = 0, failures = 0;
  bit   done = 0, mon_on = 0;
  logic eb_d1 = 0, eb_d2 = 0;
  logic [7:0] model [16];

  always #4 clk = ~clk;

  ser3_regslave u0 (
    .clk(clk), .rst_n(rst_n), .ce_main(ce_main), .ce_aux(ce_aux), .sclk(sclk),
    .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .fout_en(fout_en)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock reference: R10 two-clock delay, R2 high impedance with ce_main low
  always @(negedge clk) begin
    if (mon_on) begin
      check(fout_en === eb_d2, "R10 fout_en per clock", fout_en, eb_d2);
      if (!ce_main) check(sdio_oe === 1'b0, "R2 oe with ce_main low", sdio_oe, 0);
    end
    eb_d2 = eb_d1;
    eb_d1 = ce_aux;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic set_ce(input logic m, input logic a);
    if (ce_main && !m) for (int i = 0; i < 1; i++) model[15] &= 8'hF8;
    ce_main = m;
    ce_aux  = a;
    #1;
    if (!m) check(sdio_oe === 1'b0, "R2 oe at ce_main drop", sdio_oe, 0);
    tick(6);
  endtask

  task automatic send_bit(input logic b);
    sdio_in = b; tick(2);
    sclk = 1; tick(4);
    sclk = 0; tick(4);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      v[i] = sdio_out;
      sclk = 1; tick(4);
      sclk = 0; tick(4);
    end
  endtask

  task automatic write_seq(input logic [3:0] a, input logic [7:0] d0, input logic [7:0] d1,
                           input int n);
    send_byte({a, 4'b0011});
    send_byte(d0); model[a] = d0;
    if (n > 1) begin send_byte(d1); model[4'(a + 1)] = d1; end
  endtask

  task automatic read_cmp(input logic [3:0] a, input int n, input string tag);
    logic [7:0] v;
    set_ce(1, 1);
    send_byte({a, 4'b1100});
    check(sdio_oe === 1'b1, "R6 oe after read command", sdio_oe, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(v);
      check(v === model[4'(a + i)], tag, v, model[4'(a + i)]);
    end
    set_ce(0, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    tick(3);
    rst_n = 1;
    tick(2);
    mon_on = 1;
    check(sdio_oe === 1'b0, "R11 oe after reset", sdio_oe, 0);
    check(fout_en === 1'b0, "R11 fout_en after reset", fout_en, 0);
    read_cmp(4'd0, 16, "R11 register reset value");

    // R3/R4/R7: multi-byte write and read-back, MSB first
    set_ce(1, 1);
    write_seq(4'd2, 8'hA5, 8'h3C, 2);
    send_byte(8'h96); model[4] = 8'h96;
    set_ce(0, 0);
    read_cmp(4'd2, 3, "R3/R4 write then read");

    // R7: wrap from 15 to 0; R9 clears the low bits of register 15
    set_ce(1, 1);
    write_seq(4'd15, 8'h5A, 8'hC3, 2);
    set_ce(0, 0);
    read_cmp(4'd15, 2, "R7/R9 wrap and clear");

    // R5: partial byte dropped
    set_ce(1, 1);
    write_seq(4'd5, 8'h77, 8'h00, 1);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    set_ce(0, 0);
    read_cmp(4'd5, 2, "R5 partial byte");

    // R8: reserved mode codes
    set_ce(1, 1);
    send_byte({4'd8, 4'b0101});
    check(sdio_oe === 1'b0, "R8 oe with reserved code", sdio_oe, 0);
    send_byte(8'hFF);
    set_ce(0, 0);
    set_ce(1, 1);
    send_byte({4'd8, 4'b1101});
    check(sdio_oe === 1'b0, "R8 oe with near-read code", sdio_oe, 0);
    set_ce(0, 0);
    read_cmp(4'd8, 1, "R8 no store on reserved code");

    // R1: only ce_main high, nothing happens
    set_ce(1, 0);
    send_byte({4'd9, 4'b0011});
    send_byte(8'h44);
    set_ce(1, 0);
    send_byte({4'd9, 4'b1100});
    check(sdio_oe === 1'b0, "R1 no drive without ce_aux", sdio_oe, 0);
    set_ce(0, 0);
    read_cmp(4'd9, 1, "R1 no store without both enables");

    // R9: ce_aux drop alone keeps control bits
    set_ce(1, 1);
    write_seq(4'd15, 8'hFF, 8'h00, 1);
    set_ce(1, 0);
    set_ce(1, 1);
    send_byte({4'd15, 4'b1100});
    begin
      logic [7:0] v;
      recv_byte(v);
      check(v === 8'hFF, "R9 aux drop keeps control bits", v, 8'hFF);
    end
    set_ce(0, 0);
    read_cmp(4'd15, 1, "R9 main drop clears control bits");
    check(model[15] === 8'hF8, "R9 expected value after clear", model[15], 8'hF8);

    // R10: fout_en follows ce_aux with ce_main low
    set_ce(0, 1);
    check(fout_en === 1'b1, "R10 fout_en high", fout_en, 1);
    set_ce(0, 0);
    check(fout_en === 1'b0, "R10 fout_en low", fout_en, 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule